// File: doc/BRIEF.md
# YCbCr 4:2:2 Video Output Formatter

This block sits at the end of a video pipeline. It takes one 4:2:2 pixel per pixel strobe: a luma byte, a chroma byte that alternates between Cb and Cr from one pixel to the next, and four timing flags. The flags are the horizontal window, vertical blanking, field and valid video. The block drives the result onto two 8-bit output ports. It also divides the system clock into the pixel-rate enable and the double-rate and half-rate line-locked enables. It presents one of these enables as the selected output strobe.

A 2-bit format field selects how timing reaches the receiver:
- **Separate syncs:** the timing flags go out on their own pins.
- **Embedded headers:** a four-word FF 00 00 XY header is written into the blanking next to every active window edge.
- **Single code:** one control word marks each window edge.

A width control picks the layout:
- **16-bit layout:** luma goes on port A and chroma on port B.
- **8-bit layout:** chroma and luma bytes alternate on port A at twice the pixel rate. Port B then repeats a general-purpose value.

Timing flags are carried alongside the data through a four-pixel lookahead line. A header can therefore be placed in the blanking that comes before the window it announces.

Assumptions on the input: the formatter is fed only 4:2:2 data. Horizontal blanking lasts at least eight pixels on each side of the window. The control inputs change only while the block is held in reset.

Top module: `vid_out_fmt`

## Requirements
- R1: With divider DIV (default 4), these strobes are produced:
  - `pix_stb` is high one clock in every DIV.
  - `dbl_stb` is high twice per DIV clocks: on the `pix_stb` clock and on the clock DIV/2 earlier.
  - `half_stb` is high on every second `pix_stb`.
  - `out_stb` follows `pix_stb` for `clk_mode` 0 or 3, `dbl_stb` for 1 and `half_stb` for 2.
- R2: Latency and the 16-bit separate-sync layout (`narrow`=0, `fmt_sel`=00). Each pixel is captured on a `pix_stb` edge. Four pixel strobes later it appears with Y on `port_a` and C on `port_b`. Its horizontal window, vertical blanking and valid flags appear on `ref_h`, `ref_v` and `ref_act` at the same time.
- R3: A pixel whose valid flag is low, and which is not a code slot, is output as luma 0x10 and chroma 0x80.
- R4: `fmt_sel`=11 behaves exactly like 00. No codes are inserted, and data values 0x00 and 0xFF pass through unchanged.
- R5: With `fmt_sel`=01 in the 16-bit layout, a header is placed on both ports:
  - Start-of-line header: the four pixel slots just before the first pixel with the window flag high carry FF, 00, 00, XY.
  - End-of-line header: the four pixel slots beginning at the first pixel after the window flag falls carry the same sequence.
- R6: The header word XY has these bits, MSB first:
  - 1, F, V, H, then V^H, F^H, F^V, F^V^H.
  - F and V are the field and vertical blanking flags of that output pixel.
  - H is 1 for the end-of-line header and 0 for the start-of-line header.
- R7: With `fmt_sel`=10, one pixel slot carries the control word, on every byte that slot drives:
  - 0xFF in the slot just before the window.
  - 0x00 in the first slot after the window.
- R8: In formats 01 and 10, valid data bytes of 0x00 are output as 0x01, and 0xFF as 0xFE.
- R9: With `narrow`=1, each pixel slot puts its chroma byte on `port_a` at the pixel strobe edge, then its luma byte at the mid-pixel `dbl_stb` edge. Because input chroma alternates, the byte order is Cb Y Cr Y.
- R10: With `narrow`=1, `port_b` equals `gpo_val` at all times.
- R11: With `narrow`=1 and `fmt_sel`=01, each header occupies two pixel slots (bytes FF,00 then 00,XY) next to the window edge.
- R12: During and right after reset:
  - `port_a` is 0x10 and `port_b` is 0x80.
  - `ref_h`, `ref_v` and `ref_act` are 0.
  - `pix_stb` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, DIV times the pixel rate |
| rst | input | 1 | Synchronous active-high reset |
| fmt_sel | input | 2 | 00/11 separate syncs, 01 embedded headers, 10 single codes |
| narrow | input | 1 | 1 selects the 8-bit layout on port A only |
| gpo_val | input | 8 | Value driven on port B in the 8-bit layout |
| clk_mode | input | 2 | Output strobe select: 0 single, 1 double, 2 half |
| in_y | input | 8 | Luma sample |
| in_c | input | 8 | Chroma sample, Cb and Cr alternating |
| in_href | input | 1 | Horizontal active window flag |
| in_vref | input | 1 | Vertical blanking flag |
| in_field | input | 1 | Field flag |
| in_vact | input | 1 | Valid video flag |
| pix_stb | output | 1 | Pixel-rate enable; inputs are captured on it |
| dbl_stb | output | 1 | Double-rate enable |
| half_stb | output | 1 | Half-rate enable |
| out_stb | output | 1 | Selected output strobe |
| port_a | output | 8 | Luma (16-bit) or multiplexed bytes (8-bit) |
| port_b | output | 8 | Chroma (16-bit) or general-purpose value (8-bit) |
| ref_h | output | 1 | Delayed horizontal window flag |
| ref_v | output | 1 | Delayed vertical blanking flag |
| ref_act | output | 1 | Delayed valid flag |

## Verification
A pixel is driven at the falling edge where `pix_stb` is high and is captured at the next rising edge. That same edge loads the ports with the pixel captured four strobes earlier. The bench therefore checks pixel n-4 at the falling edge that follows the capture of pixel n. In the 8-bit layout, the luma byte is due at the mid-pixel `dbl_stb` edge, two clocks later. It is checked at the falling edge after that edge. All eight format and width combinations are swept over three lines: a vertically blanked line and two active lines. The data contains 0x00 and 0xFF values. Expected bytes, headers and XY words are computed in the bench from the line geometry.

// File: rtl/vof_pkg.sv
package vof_pkg;

    localparam logic [7:0] BLANK_Y = 8'h10;
    localparam logic [7:0] BLANK_C = 8'h80;
    localparam logic [7:0] MARK_HI = 8'hFF;
    localparam logic [7:0] MARK_LO = 8'h00;
    localparam int         LOOKAHEAD = 4;

    typedef enum logic [1:0] {
        FMT_SEP  = 2'd0,
        FMT_HDR  = 2'd1,
        FMT_CODE = 2'd2,
        FMT_RSV  = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        CK_SINGLE = 2'd0,
        CK_DOUBLE = 2'd1,
        CK_HALF   = 2'd2,
        CK_SPARE  = 2'd3
    } ck_e;

    typedef struct packed {
        logic [7:0] y;
        logic [7:0] c;
        logic       href;
        logic       vref;
        logic       field;
        logic       vact;
    } pix_t;

    localparam pix_t PIX_IDLE = '{y: BLANK_Y, c: BLANK_C, href: 1'b0,
                                  vref: 1'b0, field: 1'b0, vact: 1'b0};

    function automatic logic [7:0] xy_word(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    function automatic logic [7:0] clip8(input logic [7:0] b);
        if (b == 8'h00) return 8'h01;
        if (b == 8'hFF) return 8'hFE;
        return b;
    endfunction

    function automatic logic [7:0] hdr_byte(input logic [1:0] idx, input logic [7:0] xy);
        case (idx)
            2'd0:    return MARK_HI;
            2'd3:    return xy;
            default: return MARK_LO;
        endcase
    endfunction

endpackage

// File: rtl/vof_clk_gen.sv
module vof_clk_gen
    import vof_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] ck_sel,
    output logic       pix_stb,
    output logic       dbl_stb,
    output logic       half_stb,
    output logic       out_stb
);
    localparam int            CW   = $clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);
    localparam logic [CW-1:0] MID  = CW'(DIV / 2 - 1);

    logic [CW-1:0] cnt;
    logic          tog;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            tog <= 1'b0;
        end else begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
            if (cnt == LAST) tog <= ~tog;
        end
    end

    assign pix_stb  = (cnt == LAST);
    assign dbl_stb  = pix_stb || (cnt == MID);
    assign half_stb = pix_stb && tog;

    always_comb begin
        case (ck_e'(ck_sel))
            CK_DOUBLE: out_stb = dbl_stb;
            CK_HALF:   out_stb = half_stb;
            default:   out_stb = pix_stb;
        endcase
    end

    // R1
    pix_gap_chk: assert property (@(posedge clk) disable iff (rst)
        pix_stb |=> !pix_stb);

    // R1
    mid_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        pix_stb |=> !dbl_stb);

endmodule

// File: rtl/vof_delay.sv
module vof_delay
    import vof_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  pix_t             din,
    output pix_t             last,
    output logic [DEPTH-2:0] href_taps
);
    pix_t stg [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst)     stg[0] <= PIX_IDLE;
                else if (en) stg[0] <= din;
            end
        end else begin : g_tail
            always_ff @(posedge clk) begin
                if (rst)     stg[i] <= PIX_IDLE;
                else if (en) stg[i] <= stg[i-1];
            end
        end
        if (i < DEPTH - 1) begin : g_tap
            assign href_taps[i] = stg[i].href;
        end
    end

    assign last = stg[DEPTH-1];

    // R2
    stage_load_chk: assert property (@(posedge clk) disable iff (rst)
        en |=> stg[0] == $past(din));

endmodule

// File: rtl/vof_fmt.sv
module vof_fmt
    import vof_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pix_stb,
    input  logic                 dbl_stb,
    input  logic [1:0]           fmt_sel,
    input  logic                 narrow,
    input  pix_t                 cur,
    input  logic [LOOKAHEAD:1]   fut_href,
    output logic [7:0]           pa,
    output logic [7:0]           pb,
    output logic                 ref_h,
    output logic                 ref_v,
    output logic                 ref_act
);
    fmt_e       fmt;
    logic       embed, single;
    logic [2:0] hl;
    logic [4:0] hv;
    logic       sav_start, eav_start, start, in_code, is_eav;
    logic [1:0] slot;
    logic [7:0] xy, yv, cv, a0, a1, b;

    logic       run, kind_eav;
    logic [1:0] idx;
    logic [7:0] hold;

    always_comb begin
        fmt       = fmt_e'(fmt_sel);
        embed     = (fmt == FMT_HDR) || (fmt == FMT_CODE);
        single    = (fmt == FMT_CODE);
        hl        = single ? 3'd1 : (narrow ? 3'd2 : 3'd4);
        hv        = {fut_href, cur.href};
        sav_start = embed && !cur.href && hv[hl] && !hv[hl - 3'd1];
        eav_start = embed && !cur.href && ref_h;
        start     = sav_start || eav_start;
        in_code   = start || run;
        slot      = start ? 2'd0 : idx;
        is_eav    = start ? eav_start : kind_eav;
        xy        = xy_word(cur.field, cur.vref, is_eav);
        yv        = cur.vact ? (embed ? clip8(cur.y) : cur.y) : BLANK_Y;
        cv        = cur.vact ? (embed ? clip8(cur.c) : cur.c) : BLANK_C;
        if (in_code) begin
            if (single) begin
                a0 = is_eav ? MARK_LO : MARK_HI;
                a1 = a0;
                b  = a0;
            end else if (narrow) begin
                a0 = hdr_byte({slot[0], 1'b0}, xy);
                a1 = hdr_byte({slot[0], 1'b1}, xy);
                b  = a0;
            end else begin
                a0 = hdr_byte(slot, xy);
                a1 = a0;
                b  = a0;
            end
        end else if (narrow) begin
            a0 = cv;
            a1 = yv;
            b  = cv;
        end else begin
            a0 = yv;
            a1 = yv;
            b  = cv;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run      <= 1'b0;
            kind_eav <= 1'b0;
            idx      <= 2'd0;
            pa       <= BLANK_Y;
            hold     <= BLANK_Y;
            pb       <= BLANK_C;
            ref_h    <= 1'b0;
            ref_v    <= 1'b0;
            ref_act  <= 1'b0;
        end else if (pix_stb) begin
            pa      <= a0;
            hold    <= a1;
            pb      <= b;
            ref_h   <= cur.href;
            ref_v   <= cur.vref;
            ref_act <= cur.vact;
            if (start) begin
                kind_eav <= eav_start;
                idx      <= 2'd1;
                run      <= (hl > 3'd1);
            end else if (run) begin
                idx <= idx + 2'd1;
                if ({1'b0, idx} == hl - 3'd1) run <= 1'b0;
            end
        end else if (dbl_stb && narrow) begin
            pa <= hold;
        end
    end

    // R3
    blank_chk: assert property (@(posedge clk) disable iff (rst)
        pix_stb && !narrow && !in_code && !cur.vact |=> pa == BLANK_Y && pb == BLANK_C);

    // R8
    clip_chk: assert property (@(posedge clk) disable iff (rst)
        pix_stb && embed && !in_code |=> pa != 8'h00 && pa != 8'hFF);

    // R9
    byte_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !pix_stb && !dbl_stb |=> $stable(pa));

    // R5
    sav_lead_chk: assert property (@(posedge clk) disable iff (rst)
        pix_stb && sav_start && !single |=> pa == MARK_HI);

    // R7
    eav_code_chk: assert property (@(posedge clk) disable iff (rst)
        pix_stb && eav_start && single |=> pa == MARK_LO && pb == MARK_LO);

    // R2
    ref_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !pix_stb |=> $stable(ref_h) && $stable(ref_act));

endmodule

// File: rtl/vid_out_fmt.sv
module vid_out_fmt
    import vof_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] fmt_sel,
    input  logic       narrow,
    input  logic [7:0] gpo_val,
    input  logic [1:0] clk_mode,
    input  logic [7:0] in_y,
    input  logic [7:0] in_c,
    input  logic       in_href,
    input  logic       in_vref,
    input  logic       in_field,
    input  logic       in_vact,
    output logic       pix_stb,
    output logic       dbl_stb,
    output logic       half_stb,
    output logic       out_stb,
    output logic [7:0] port_a,
    output logic [7:0] port_b,
    output logic       ref_h,
    output logic       ref_v,
    output logic       ref_act
);
    pix_t                  din, last;
    logic [LOOKAHEAD-2:0]  taps;
    logic [LOOKAHEAD:1]    fut;
    logic [7:0]            pb_int;

    assign din = '{y: in_y, c: in_c, href: in_href, vref: in_vref,
                   field: in_field, vact: in_vact};

    vof_clk_gen #(.DIV(DIV)) u_clk (
        .clk      (clk),
        .rst      (rst),
        .ck_sel   (clk_mode),
        .pix_stb  (pix_stb),
        .dbl_stb  (dbl_stb),
        .half_stb (half_stb),
        .out_stb  (out_stb)
    );

    vof_delay #(.DEPTH(LOOKAHEAD)) u_dly (
        .clk       (clk),
        .rst       (rst),
        .en        (pix_stb),
        .din       (din),
        .last      (last),
        .href_taps (taps)
    );

    for (genvar k = 1; k <= LOOKAHEAD; k++) begin : g_fut
        if (k == LOOKAHEAD) begin : g_in
            assign fut[k] = in_href;
        end else begin : g_tap
            assign fut[k] = taps[LOOKAHEAD-1-k];
        end
    end

    vof_fmt u_fmt (
        .clk      (clk),
        .rst      (rst),
        .pix_stb  (pix_stb),
        .dbl_stb  (dbl_stb),
        .fmt_sel  (fmt_sel),
        .narrow   (narrow),
        .cur      (last),
        .fut_href (fut),
        .pa       (port_a),
        .pb       (pb_int),
        .ref_h    (ref_h),
        .ref_v    (ref_v),
        .ref_act  (ref_act)
    );

    assign port_b = narrow ? gpo_val : pb_int;

endmodule

// File: tb/tb_vid_out_fmt.sv
module tb_vid_out_fmt;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] fmt_sel;
    logic       narrow;
    logic [7:0] gpo_val;
    logic [1:0] clk_mode;
    logic [7:0] in_y, in_c;
    logic       in_href, in_vref, in_field, in_vact;
    logic       pix_stb, dbl_stb, half_stb, out_stb;
    logic [7:0] port_a, port_b;
    logic       ref_h, ref_v, ref_act;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 0;

    localparam int LINE = 24;
    localparam int NPIX = 72;
    localparam int NRUN = 80;

    always #5 clk = ~clk;

    vid_out_fmt dut (
        .clk(clk), .rst(rst), .fmt_sel(fmt_sel), .narrow(narrow),
        .gpo_val(gpo_val), .clk_mode(clk_mode),
        .in_y(in_y), .in_c(in_c), .in_href(in_href), .in_vref(in_vref),
        .in_field(in_field), .in_vact(in_vact),
        .pix_stb(pix_stb), .dbl_stb(dbl_stb), .half_stb(half_stb),
        .out_stb(out_stb), .port_a(port_a), .port_b(port_b),
        .ref_h(ref_h), .ref_v(ref_v), .ref_act(ref_act)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
        end
    endtask

    // stimulus geometry
    function automatic bit s_href(int n);
        int col;
        if (n < 0 || n >= NPIX) return 1'b0;
        col = n % LINE;
        return (col >= 10) && (col < 20);
    endfunction

    function automatic bit s_vref(int n);
        return (n >= 0) && (n < NPIX) && (n / LINE == 0);
    endfunction

    function automatic bit s_field(int n);
        return (n >= 0) && (n < NPIX) && (n / LINE == 2);
    endfunction

    function automatic bit s_vact(int n);
        return s_href(n) && !s_vref(n);
    endfunction

    function automatic logic [7:0] s_y(int n);
        if (n % 5 == 0) return 8'hFF;
        if (n % 7 == 0) return 8'h00;
        return 8'(n * 3 + 1);
    endfunction

    function automatic logic [7:0] s_c(int n);
        if (n % 6 == 1) return 8'h00;
        if (n % 6 == 4) return 8'hFF;
        return 8'(8'h40 + n);
    endfunction

    function automatic logic [7:0] cl(logic [7:0] b);
        if (b == 8'h00) return 8'h01;
        if (b == 8'hFF) return 8'hFE;
        return b;
    endfunction

    task automatic expect_px(input int p, input int f, input bit nar,
                             output logic [7:0] a0, output logic [7:0] a1,
                             output logic [7:0] b, output string tag);
        bit         embed, single, code, eav, fb, vb;
        int         hl, slot;
        logic [7:0] h [4];
        logic [7:0] y, c;
        embed  = (f == 1) || (f == 2);
        single = (f == 2);
        hl     = single ? 1 : (nar ? 2 : 4);
        code = 0; eav = 0; slot = 0;
        if (embed && !s_href(p)) begin
            for (int d = 1; d <= hl; d++)
                if (s_href(p + d) && !s_href(p + d - 1)) begin
                    code = 1; slot = hl - d;
                end
            for (int k = 0; k < hl; k++)
                if (!s_href(p - k) && s_href(p - k - 1)) begin
                    code = 1; eav = 1; slot = k;
                end
        end
        fb = s_field(p);
        vb = s_vref(p);
        h[0] = 8'hFF; h[1] = 8'h00; h[2] = 8'h00;
        h[3] = {1'b1, fb, vb, eav, vb ^ eav, fb ^ eav, fb ^ vb, fb ^ vb ^ eav};
        if (code) begin
            if (single) begin
                tag = "R7";
                a0 = eav ? 8'h00 : 8'hFF; a1 = a0; b = a0;
            end else if (nar) begin
                tag = "R11 R6";
                a0 = h[2*slot]; a1 = h[2*slot+1]; b = a0;
            end else begin
                tag = "R5 R6";
                a0 = h[slot]; a1 = a0; b = a0;
            end
        end else begin
            if (s_vact(p)) begin
                y = embed ? cl(s_y(p)) : s_y(p);
                c = embed ? cl(s_c(p)) : s_c(p);
                tag = embed ? "R8" : (f == 3 ? "R4" : (nar ? "R9" : "R2"));
            end else begin
                y = 8'h10; c = 8'h80;
                tag = "R3";
            end
            if (nar) begin a0 = c; a1 = y; b = c; end
            else     begin a0 = y; a1 = y; b = c; end
        end
    endtask

    task automatic wait_pix();
        do @(negedge clk); while (!pix_stb);
    endtask

    task automatic run_config(input int f, input bit nar);
        logic [7:0] a0, a1, b;
        string      tag;
        fmt_sel = 2'(f);
        narrow  = nar;
        gpo_val = 8'hA5 ^ 8'(f * 2 + int'(nar));
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        for (int n = 0; n < NRUN; n++) begin
            wait_pix();
            in_y = s_y(n); in_c = s_c(n);
            in_href = s_href(n); in_vref = s_vref(n);
            in_field = s_field(n); in_vact = s_vact(n);
            @(posedge clk);
            @(negedge clk);
            expect_px(n - 4, f, nar, a0, a1, b, tag);
            chk({tag, " port_a first"}, port_a, a0);
            if (nar) chk("R10 port_b gpo", port_b, gpo_val);
            else     chk({tag, " port_b"}, port_b, b);
            chk("R2 ref_h", ref_h, s_href(n - 4));
            chk("R2 ref_v", ref_v, s_vref(n - 4));
            chk("R2 ref_act", ref_act, s_vact(n - 4));
            if (nar) begin
                repeat (2) @(posedge clk);
                @(negedge clk);
                chk({tag, " R9 port_a second"}, port_a, a1);
                chk("R10 port_b gpo", port_b, gpo_val);
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R12 actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int np, nd, nh, no;
        rst = 1'b1; fmt_sel = 2'd0; narrow = 1'b0; gpo_val = 8'h00;
        clk_mode = 2'd0; in_y = 8'h00; in_c = 8'h00;
        in_href = 1'b0; in_vref = 1'b0; in_field = 1'b0; in_vact = 1'b0;
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12 port_a", port_a, 8'h10);
        chk("R12 port_b", port_b, 8'h80);
        chk("R12 refs", {ref_h, ref_v, ref_act}, 0);
        chk("R12 pix_stb", pix_stb, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R12 port_a after release", port_a, 8'h10);
        // R1 strobe rates and output strobe select
        for (int m = 0; m < 4; m++) begin
            clk_mode = 2'(m);
            np = 0; nd = 0; nh = 0; no = 0;
            for (int i = 0; i < 32; i++) begin
                @(negedge clk);
                np += int'(pix_stb); nd += int'(dbl_stb);
                nh += int'(half_stb); no += int'(out_stb);
            end
            chk("R1 pix_stb count", np, 8);
            chk("R1 dbl_stb count", nd, 16);
            chk("R1 half_stb count", nh, 4);
            chk("R1 out_stb count", no, (m == 1) ? 16 : ((m == 2) ? 4 : 8));
        end
        clk_mode = 2'd0;
        for (int f = 0; f < 4; f++)
            for (int w = 0; w < 2; w++)
                run_config(f, w[0]);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule